// File: doc/BRIEF.md
# 32-bit Integer Execute ALU

This block is the integer execute stage of a small load/store processor core. Each cycle it takes a 4-bit operation code, two 32-bit register operands, a 16-bit immediate, a 5-bit encoded shift amount and a select that says where the shift amount comes from. From these it forms one 32-bit result.

The operations are:
- an add of a sign-extended immediate;
- the four bitwise logic functions;
- signed and unsigned compares that yield 0 or 1;
- placing the immediate in the upper half of the word;
- left, logical-right, arithmetic-right and rotate-right shifts;
- sign extension of a byte or a halfword;
- a swap of the two bytes inside each halfword.

There are no flags and no traps. The add simply wraps.

A build-time parameter chooses how the result leaves the block. It can come out combinationally, or through an output register that has a clock enable. In the registered variant the asynchronous reset is released through a two-stage synchronizer.

Top module: `int_exec_alu`

## Requirements
- R1: Op code 0 (add-immediate) returns opa plus the immediate sign-extended from bit 15, wrapping modulo 2^32 without any flag.
- R2: Op codes 1, 2, 3 and 4 return opa AND opb, opa OR opb, opa XOR opb and the inverted OR of both, in that order.
- R3: Op code 7 returns the immediate in bits 31:16 with bits 15:0 zero.
- R4: Op code 5 returns 1 when opa is less than opb as two's-complement numbers, and 0 otherwise. Op code 6 does the same for unsigned numbers. This holds also where opa minus opb overflows. Bits 31:1 are always zero.
- R5: With amt_from_reg high, the shift amount is opa bits 4:0 and opa bits 31:5 have no effect. With amt_from_reg low, the amount is the shamt port.
- R6: Op code 8 shifts opb left, op code 9 shifts opb right, and both fill with zeros. Op code 10 shifts opb right and fills with copies of bit 31.
- R7: Op code 11 rotates opb right: bit i moves to position (i − n) mod 32.
- R8: Op code 12 copies opb bit 7 into bits 31:8 above opb[7:0]. Op code 13 copies opb bit 15 into bits 31:16 above opb[15:0].
- R9: Op code 14 returns {opb[23:16], opb[31:24], opb[7:0], opb[15:8]}.
- R10: Op code 15 returns zero.
- R11: With REG_OUT=1, result shows the value for the inputs present at the last rising edge where en was high. It holds while en is low. It clears at once when rst_n falls and stays zero for two rising edges after rst_n rises. With REG_OUT=0, result follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable of the output register |
| op | input | 4 | Operation code |
| opa | input | 32 | First register operand, also the register shift amount source |
| opb | input | 32 | Second register operand, the value that is shifted or extended |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Encoded shift amount |
| amt_from_reg | input | 1 | Selects opa[4:0] instead of shamt as the shift amount |
| result | output | 32 | Operation result |

## Verification
The bench creates two instances of the block: one with REG_OUT=0 and one with REG_OUT=1. Both see the same stimulus and are checked against the same behavioural model. The combinational instance exposes every operation in the cycle it is applied. The registered instance brings the clock enable hold, the asynchronous clear during operation and the two-cycle synchronized release into reach. Directed vectors cover:
- compare overflow pairs;
- shift amounts of 0 and 31;
- opa values with garbage above bit 4;
- the unused op code.

// File: rtl/int_exec_alu_pkg.sv
`timescale 1ns/1ps
package int_exec_alu_pkg;
  localparam int XLEN   = 32;
  localparam int SHW    = $clog2(XLEN);
  localparam int IMMW   = 16;
  localparam int OPW    = 4;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  typedef enum logic [OPW-1:0] {
    OP_ADDI = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_LUI  = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10,
    OP_ROTR = 4'd11,
    OP_SEB  = 4'd12,
    OP_SEH  = 4'd13,
    OP_WSBH = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_LOGIC = 2'd1,
    SH_ARITH = 2'd2,
    SH_ROT   = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/int_exec_alu_arith.sv
`timescale 1ns/1ps
module int_exec_alu_arith
  import int_exec_alu_pkg::*;
(
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] sum_imm,
  output logic            lt_signed,
  output logic            lt_unsigned,
  output logic [XLEN-1:0] upper_imm
);
  localparam int PADW = XLEN - IMMW;

  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] ovf_fix;

  assign imm_sx  = {{PADW{imm[IMMW-1]}}, imm};
  assign sum_imm = opa + imm_sx;

  // Sign of the difference, corrected where the subtraction overflowed.
  assign diff        = opa - opb;
  assign ovf_fix     = diff ^ ((opa ^ opb) & (diff ^ opa));
  assign lt_signed   = ovf_fix[XLEN-1];
  assign lt_unsigned = ovf_fix[XLEN-1] ^ opa[XLEN-1] ^ opb[XLEN-1];

  assign upper_imm = {imm, {PADW{1'b0}}};
endmodule

// File: rtl/int_exec_alu_bitops.sv
`timescale 1ns/1ps
module int_exec_alu_bitops
  import int_exec_alu_pkg::*;
(
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] and_o,
  output logic [XLEN-1:0] or_o,
  output logic [XLEN-1:0] xor_o,
  output logic [XLEN-1:0] nor_o,
  output logic [XLEN-1:0] sext_b,
  output logic [XLEN-1:0] sext_h,
  output logic [XLEN-1:0] swap_h
);
  localparam int NHALF = XLEN / HALF_W;

  assign and_o = opa & opb;
  assign or_o  = opa | opb;
  assign xor_o = opa ^ opb;
  assign nor_o = or_o ^ {XLEN{1'b1}};

  assign sext_b = {{(XLEN-BYTE_W){opb[BYTE_W-1]}}, opb[BYTE_W-1:0]};
  assign sext_h = {{(XLEN-HALF_W){opb[HALF_W-1]}}, opb[HALF_W-1:0]};

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam int LO = h * HALF_W;
    assign swap_h[LO +: BYTE_W]          = opb[LO + BYTE_W +: BYTE_W];
    assign swap_h[LO + BYTE_W +: BYTE_W] = opb[LO +: BYTE_W];
  end
endmodule

// File: rtl/int_exec_alu_shift.sv
`timescale 1ns/1ps
module int_exec_alu_shift
  import int_exec_alu_pkg::*;
(
  input  logic [XLEN-1:0] src,
  input  logic [SHW-1:0]  amt,
  input  shift_kind_e     kind,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] src_rev;
  logic [XLEN-1:0] last_rev;
  logic [XLEN-1:0] stage [0:SHW];
  logic            fill_bit;

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign src_rev[i]  = src[XLEN-1-i];
    assign last_rev[i] = stage[SHW][XLEN-1-i];
  end

  // A left shift is a right shift of the bit-reversed word.
  assign fill_bit = (kind == SH_ARITH) & src[XLEN-1];
  assign stage[0] = (kind == SH_LEFT) ? src_rev : src;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [STEP-1:0] fill;
    assign fill = (kind == SH_ROT) ? stage[k][STEP-1:0] : {STEP{fill_bit}};
    assign stage[k+1] = amt[k] ? {fill, stage[k][XLEN-1:STEP]} : stage[k];
  end

  assign dout = (kind == SH_LEFT) ? last_rev : stage[SHW];
endmodule

// File: rtl/int_exec_alu.sv
`timescale 1ns/1ps
module int_exec_alu
  import int_exec_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [IMMW-1:0] imm,
  input  logic [SHW-1:0]  shamt,
  input  logic            amt_from_reg,
  output logic [XLEN-1:0] result
);
  alu_op_e         op_e;
  logic [SHW-1:0]  amt;
  shift_kind_e     kind;
  logic [XLEN-1:0] sum_imm, upper_imm, shifted;
  logic            lt_signed, lt_unsigned;
  logic [XLEN-1:0] and_o, or_o, xor_o, nor_o, sext_b, sext_h, swap_h;
  logic [XLEN-1:0] res_nxt;
  logic            rst_sync_n;

  assign op_e = alu_op_e'(op);
  assign amt  = amt_from_reg ? opa[SHW-1:0] : shamt;

  always_comb begin
    unique case (op_e)
      OP_SLL:  kind = SH_LEFT;
      OP_SRA:  kind = SH_ARITH;
      OP_ROTR: kind = SH_ROT;
      default: kind = SH_LOGIC;
    endcase
  end

  int_exec_alu_arith u_arith (
    .opa(opa), .opb(opb), .imm(imm),
    .sum_imm(sum_imm), .lt_signed(lt_signed),
    .lt_unsigned(lt_unsigned), .upper_imm(upper_imm)
  );

  int_exec_alu_bitops u_bitops (
    .opa(opa), .opb(opb),
    .and_o(and_o), .or_o(or_o), .xor_o(xor_o), .nor_o(nor_o),
    .sext_b(sext_b), .sext_h(sext_h), .swap_h(swap_h)
  );

  int_exec_alu_shift u_shift (
    .src(opb), .amt(amt), .kind(kind), .dout(shifted)
  );

  always_comb begin
    res_nxt = '0;
    case (op_e)
      OP_ADDI: res_nxt = sum_imm;
      OP_AND:  res_nxt = and_o;
      OP_OR:   res_nxt = or_o;
      OP_XOR:  res_nxt = xor_o;
      OP_NOR:  res_nxt = nor_o;
      OP_SLT:  res_nxt = {{(XLEN-1){1'b0}}, lt_signed};
      OP_SLTU: res_nxt = {{(XLEN-1){1'b0}}, lt_unsigned};
      OP_LUI:  res_nxt = upper_imm;
      OP_SLL, OP_SRL, OP_SRA, OP_ROTR: res_nxt = shifted;
      OP_SEB:  res_nxt = sext_b;
      OP_SEH:  res_nxt = sext_h;
      OP_WSBH: res_nxt = swap_h;
      default: res_nxt = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic [1:0]      rs_q;
    logic [XLEN-1:0] res_q, res_d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rs_q <= '0;
      else        rs_q <= {rs_q[0], 1'b1};
    end
    assign rst_sync_n = rs_q[1];

    always_comb begin
      res_d = res_q;
      if (en) res_d = res_nxt;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) res_q <= '0;
      else             res_q <= res_d;
    end
    assign result = res_q;
  end else begin : g_comb
    assign rst_sync_n = rst_n;
    assign result     = res_nxt;
  end
endmodule

// File: rtl/int_exec_alu_chk.sv
`timescale 1ns/1ps
module int_exec_alu_chk
  import int_exec_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_sync_n,
  input logic            en,
  input logic [OPW-1:0]  op,
  input logic [XLEN-1:0] opb,
  input logic [IMMW-1:0] imm,
  input logic [XLEN-1:0] res_nxt,
  input logic [XLEN-1:0] result
);
  p_upper_imm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LUI) |-> (res_nxt[HALF_W-1:0] == '0 && res_nxt[XLEN-1:HALF_W] == imm));

  p_cmp_bool_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SLT || op == OP_SLTU) |-> (res_nxt[XLEN-1:1] == '0));

  p_sext_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SEB) |-> ($countones(res_nxt[XLEN-1:BYTE_W]) == (opb[BYTE_W-1] ? XLEN-BYTE_W : 0)));

  p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |-> (res_nxt == '0));

  if (REG_OUT) begin : g_reg_chk
    p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_sync_n && en) |=> (result == $past(res_nxt)));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_sync_n && !en) |=> $stable(result));

    p_clear_r11: assert property (@(posedge clk)
      (!rst_sync_n) |-> (result == '0));
  end else begin : g_comb_chk
    p_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (result == res_nxt));
  end
endmodule

bind int_exec_alu int_exec_alu_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n), .en(en),
  .op(op), .opb(opb), .imm(imm), .res_nxt(res_nxt), .result(result)
);

// File: tb/int_exec_alu_bench.sv
`timescale 1ns/1ps
module int_exec_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opa = 32'd0;
  logic [31:0] opb = 32'd0;
  logic [15:0] imm = 16'd0;
  logic [4:0]  shamt = 5'd0;
  logic        sel = 1'b0;
  logic [31:0] res_r, res_c;

  int checks = 0;
  int failures = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  int_exec_alu #(.REG_OUT(1'b1)) u_int_exec_alu (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa), .opb(opb),
    .imm(imm), .shamt(shamt), .amt_from_reg(sel), .result(res_r)
  );

  int_exec_alu #(.REG_OUT(1'b0)) u_int_exec_alu_c (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa), .opb(opb),
    .imm(imm), .shamt(shamt), .amt_from_reg(sel), .result(res_c)
  );

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im,
                                        input logic [4:0] sa, input logic s);
    int n;
    logic signed [31:0] sb;
    n  = s ? int'(a % 32) : int'(sa);
    sb = b;
    case (o)
      4'd0:  return a + 32'($signed(im));
      4'd1:  return a & b;
      4'd2:  return a | b;
      4'd3:  return a ^ b;
      4'd4:  return ~(a | b);
      4'd5:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd6:  return (a < b) ? 32'd1 : 32'd0;
      4'd7:  return im * 32'h10000;
      4'd8:  return b << n;
      4'd9:  return b >> n;
      4'd10: return 32'(sb >>> n);
      4'd11: return (b >> n) | (b << (32 - n));
      4'd12: return 32'($signed(b[7:0]));
      4'd13: return 32'($signed(b[15:0]));
      4'd14: return {b[23:16], b[31:24], b[7:0], b[15:8]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] o, input logic s);
    if (o >= 4'd8 && o <= 4'd11 && s) return "R5";
    case (o)
      4'd0: return "R1";
      4'd1, 4'd2, 4'd3, 4'd4: return "R2";
      4'd5, 4'd6: return "R4";
      4'd7: return "R3";
      4'd8, 4'd9, 4'd10: return "R6";
      4'd11: return "R7";
      4'd12, 4'd13: return "R8";
      4'd14: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Behavioural model of the registered variant (R11).
  logic [1:0]  sync_m;
  logic [31:0] exp_q;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_m <= 2'b00;
      exp_q  <= 32'd0;
    end else begin
      sync_m <= {sync_m[0], 1'b1};
      if (sync_m[1] && en) exp_q <= model(op, opa, opb, imm, shamt, sel);
    end
  end

  always @(negedge clk) begin
    if (checking && !finished) begin
      logic [31:0] e;
      e = model(op, opa, opb, imm, shamt, sel);
      checks++;
      if (res_c !== e) begin
        failures++;
        $display("FAIL %s comb op=%0d got=%h exp=%h", tag(op, sel), op, res_c, e);
      end
      checks++;
      if (res_r !== exp_q) begin
        failures++;
        $display("FAIL R11 registered got=%h exp=%h", res_r, exp_q);
      end
    end
  end

  task automatic drive(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sa, input logic s,
                       input logic e);
    @(posedge clk);
    #2;
    op = o; opa = a; opb = b; imm = im; shamt = sa; sel = s; en = e;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checking = 1'b1;
    // R11: reset state of the registered result.
    checks++;
    if (res_r !== 32'd0) begin
      failures++;
      $display("FAIL R11 reset got=%h exp=%h", res_r, 32'd0);
    end
    rst_n = 1'b1;
    en = 1'b1;
    // R1: sign-extended immediate, wrap.
    drive(4'd0, 32'd100, 32'd0, 16'hFFFF, 5'd0, 1'b0, 1'b1);
    drive(4'd0, 32'hFFFF_FFF0, 32'd0, 16'h0020, 5'd0, 1'b0, 1'b1);
    drive(4'd0, 32'h8000_0000, 32'd0, 16'h8000, 5'd0, 1'b0, 1'b1);
    // R2: logic ops.
    for (int i = 1; i <= 4; i++) drive(4'(i), 32'hF0F0_1234, 32'h0FF0_4321, 16'd0, 5'd0, 1'b0, 1'b1);
    // R3: upper immediate.
    drive(4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF, 5'd0, 1'b0, 1'b1);
    // R4: compare overflow pairs.
    drive(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 16'd0, 5'd0, 1'b0, 1'b1);
    drive(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 16'd0, 5'd0, 1'b0, 1'b1);
    drive(4'd6, 32'h7FFF_FFFF, 32'h8000_0000, 16'd0, 5'd0, 1'b0, 1'b1);
    drive(4'd6, 32'h8000_0000, 32'h7FFF_FFFF, 16'd0, 5'd0, 1'b0, 1'b1);
    drive(4'd5, 32'h1234_5678, 32'h1234_5678, 16'd0, 5'd0, 1'b0, 1'b1);
    // R5/R6/R7: shift amount boundaries and source.
    for (int o = 8; o <= 11; o++) begin
      drive(4'(o), 32'd0, 32'h8765_4321, 16'd0, 5'd0, 1'b0, 1'b1);
      drive(4'(o), 32'd0, 32'h8765_4321, 16'd0, 5'd31, 1'b0, 1'b1);
      drive(4'(o), 32'hFFFF_FFE3, 32'h8765_4321, 16'd0, 5'd7, 1'b1, 1'b1);
      drive(4'(o), 32'h0000_0020, 32'h8765_4321, 16'd0, 5'd9, 1'b1, 1'b1);
    end
    // R8/R9: extension and swap.
    drive(4'd12, 32'd0, 32'h1234_5680, 16'd0, 5'd0, 1'b0, 1'b1);
    drive(4'd12, 32'd0, 32'hFFFF_FF7F, 16'd0, 5'd0, 1'b0, 1'b1);
    drive(4'd13, 32'd0, 32'h0000_8001, 16'd0, 5'd0, 1'b0, 1'b1);
    drive(4'd13, 32'd0, 32'hFFFF_7FFF, 16'd0, 5'd0, 1'b0, 1'b1);
    drive(4'd14, 32'd0, 32'hAABB_CCDD, 16'd0, 5'd0, 1'b0, 1'b1);
    // R10: unused code.
    drive(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, 1'b1, 1'b1);
    // R11: hold with enable low.
    drive(4'd2, 32'h5555_0000, 32'h0000_AAAA, 16'd0, 5'd0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) drive(4'(i), 32'(i * 7919), 32'hDEAD_BEEF, 16'h1357, 5'(i), 1'b0, 1'b0);
    // Random traffic with random enable.
    for (int i = 0; i < 3000; i++)
      drive(4'($urandom), $urandom, $urandom, 16'($urandom), 5'($urandom), 1'($urandom),
            ($urandom % 4) != 0);
    // R11: asynchronous clear and synchronized release.
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    checks++;
    if (res_r !== 32'd0) begin
      failures++;
      $display("FAIL R11 async clear got=%h exp=%h", res_r, 32'd0);
    end
    drive(4'd1, 32'hFFFF_FFFF, 32'h1234_5678, 16'd0, 5'd0, 1'b0, 1'b1);
    drive(4'd1, 32'hFFFF_FFFF, 32'h1234_5678, 16'd0, 5'd0, 1'b0, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) drive(4'd3, 32'(i), 32'hFFFF_0000, 16'd0, 5'd0, 1'b0, 1'b1);
    @(posedge clk);
    #2;
    finish_run();
  end
endmodule